// File: doc/BRIEF.md
# Serial Port Control and Status Register Block

This block is the software-facing side of a serial port. A simple memory-mapped read/write port reaches seven 32-bit registers: status, data, baud divisor, three control words and a guard/prescale word. Received characters arrive already deserialised as bytes on a valid/ready stream. Characters written by software leave as a one-cycle strobe carrying the byte. Framing, bit timing and parity belong to a separate shifter.

The block keeps three status flags: data-available, transmit-empty and transfer-done. They change as side effects of bus accesses and of received bytes. One level interrupt line follows the data-available flag and its enable bit. The line is set when a byte lands or when the enable is written while data is waiting. It is cleared by a data read, or by a status write that leaves data-available clear. The receive stream is back-pressured while an unread byte is held.

Top module: `serial_csr_top`

## Requirements
- R1: `rx_ready` is high exactly while status bit 5 (data-available) is clear. A byte offered while `rx_ready` is low is not taken and leaves the data register unchanged.
- R2: An accepted byte is always stored in the data register. It sets status bit 5 only when control-1 bit 13 (port enable) and control-1 bit 2 (receive enable) are both set. Otherwise the byte is dropped without setting the flag. The control-1 value used is the one held before any write in the same cycle.
- R3: When an accepted byte sets status bit 5 and control-1 bit 5 (receive interrupt enable) is set, `irq` goes high on the next cycle.
- R4: A read of offset 0x04 returns the stored byte zero-extended to 32 bits. It then sets status bit 7 (transmit-empty), clears status bit 5 and drives `irq` low.
- R5: A read of offset 0x00 returns the status value held before the read. It then clears status bit 6 (transfer-done).
- R6: A write to offset 0x00 with a value up to 0x3FF replaces the status register. A larger value is ANDed into it. If status bit 5 is then clear, `irq` goes low.
- R7: A write to offset 0x04 with a value below 0xF000 produces a one-cycle `tx_strobe` with `tx_byte` equal to the low byte. It also sets status bit 6 and clears status bit 7. Values of 0xF000 and above have no effect.
- R8: A write to offset 0x0C stores control-1. If its bit 5 is set while status bit 5 is set, `irq` goes high.
- R9: After reset, status reads 0x000000C0, every other register reads zero, and `irq`, `tx_strobe` and `rsp_valid` are low.
- R10: Offsets 0x08 (baud divisor), 0x10 (control-2), 0x14 (control-3) and 0x18 (guard/prescale) read back what was last written. Any other offset in the 0x2000-byte window, including unaligned ones, reads zero and ignores writes.
- R11: Read data appears on `rsp_rdata` with `rsp_valid` high one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus access request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W (13) | Byte offset in the register window |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W (32) | Read data |
| rx_valid | input | 1 | Received byte offered |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Block can take a byte |
| tx_strobe | output | 1 | One-cycle transmit pulse |
| tx_byte | output | 8 | Byte to transmit |
| irq | output | 1 | Level interrupt |

## Verification
The bench aims at the value thresholds. Status writes at 0x3FF and 0x400 separate replace from AND-clear: a design that picked the wrong path would leave stale bits or wipe set ones. Data writes at 0xEFFF and 0xF000 test the transmit cut-off, which a wrong compare would shift by one value. Bytes are pushed while a previous byte is unread, and with the enables off. A design that overwrote held data, or that flagged disabled bytes, shows the wrong data on the next read. The interrupt is checked for rising on a late enable write and for staying high across a control write that clears the enable.

// File: rtl/serial_csr_pkg.sv
package serial_csr_pkg;
  localparam int OFS_STATUS = 'h00;
  localparam int OFS_DATA   = 'h04;
  localparam int OFS_BAUD   = 'h08;
  localparam int OFS_CTL1   = 'h0C;
  localparam int OFS_CTL2   = 'h10;
  localparam int OFS_CTL3   = 'h14;
  localparam int OFS_GUARD  = 'h18;

  localparam int ST_TXE  = 7;
  localparam int ST_DONE = 6;
  localparam int ST_AVAIL = 5;

  localparam int C1_PORT_EN = 13;
  localparam int C1_AV_IE   = 5;
  localparam int C1_RX_EN   = 2;

  localparam int unsigned STATUS_RESET = 'h00C0;
  localparam int unsigned ST_REPLACE_MAX = 'h3FF;
  localparam int unsigned TX_LIMIT = 'hF000;

  localparam int NUM_PLAIN = 5;
  localparam int PL_BAUD  = 0;
  localparam int PL_CTL1  = 1;
  localparam int PL_CTL2  = 2;
  localparam int PL_CTL3  = 3;
  localparam int PL_GUARD = 4;

  typedef enum logic [2:0] {
    SEL_STATUS, SEL_DATA, SEL_PLAIN, SEL_NONE
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [2:0]  plain_idx;
  } reg_sel_t;
endpackage

// File: rtl/serial_csr_decode.sv
module serial_csr_decode
  import serial_csr_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:2];

  always_comb begin
    sel.kind      = SEL_NONE;
    sel.plain_idx = '0;
    if (addr[1:0] == 2'b00) begin
      case (word)
        WORD_W'(OFS_STATUS >> 2): sel.kind = SEL_STATUS;
        WORD_W'(OFS_DATA   >> 2): sel.kind = SEL_DATA;
        WORD_W'(OFS_BAUD   >> 2): begin sel.kind = SEL_PLAIN; sel.plain_idx = 3'(PL_BAUD);  end
        WORD_W'(OFS_CTL1   >> 2): begin sel.kind = SEL_PLAIN; sel.plain_idx = 3'(PL_CTL1);  end
        WORD_W'(OFS_CTL2   >> 2): begin sel.kind = SEL_PLAIN; sel.plain_idx = 3'(PL_CTL2);  end
        WORD_W'(OFS_CTL3   >> 2): begin sel.kind = SEL_PLAIN; sel.plain_idx = 3'(PL_CTL3);  end
        WORD_W'(OFS_GUARD  >> 2): begin sel.kind = SEL_PLAIN; sel.plain_idx = 3'(PL_GUARD); end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/serial_csr_store.sv
module serial_csr_store
  import serial_csr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = NUM_PLAIN
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NREG-1:0]              wr_en,
  input  logic [DATA_W-1:0]            wdata,
  output logic [NREG-1:0][DATA_W-1:0]  regs
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)           regs[g] <= '0;
      else if (wr_en[g]) regs[g] <= wdata;
    end
  end
endmodule

// File: rtl/serial_csr_flags.sv
module serial_csr_flags
  import serial_csr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_status,
  input  logic              rd_data,
  input  logic              wr_status,
  input  logic              wr_data,
  input  logic              wr_ctl1,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ctl1,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_ready,
  output logic [DATA_W-1:0] status,
  output logic [BYTE_W-1:0] data,
  output logic              irq,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_byte
);
  logic [DATA_W-1:0] status_n;
  logic [BYTE_W-1:0] data_n;
  logic              irq_n;
  logic              tx_go;
  logic              take;

  assign rx_ready = ~status[ST_AVAIL];
  assign take     = rx_valid & ~status[ST_AVAIL];
  assign tx_go    = wr_data & (wdata < DATA_W'(TX_LIMIT));

  always_comb begin
    status_n = status;
    data_n   = data;
    irq_n    = irq;
    if (rd_status) status_n[ST_DONE] = 1'b0;
    if (rd_data) begin
      status_n[ST_TXE]   = 1'b1;
      status_n[ST_AVAIL] = 1'b0;
      irq_n              = 1'b0;
    end
    if (wr_status) begin
      if (wdata <= DATA_W'(ST_REPLACE_MAX)) status_n = wdata;
      else                                  status_n = status & wdata;
      if (!status_n[ST_AVAIL]) irq_n = 1'b0;
    end
    if (tx_go) begin
      status_n[ST_DONE] = 1'b1;
      status_n[ST_TXE]  = 1'b0;
    end
    if (wr_ctl1 && wdata[C1_AV_IE] && status_n[ST_AVAIL]) irq_n = 1'b1;
    if (take) begin
      data_n = rx_byte;
      if (ctl1[C1_PORT_EN] && ctl1[C1_RX_EN]) begin
        status_n[ST_AVAIL] = 1'b1;
        if (ctl1[C1_AV_IE]) irq_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status    <= DATA_W'(STATUS_RESET);
      data      <= '0;
      irq       <= 1'b0;
      tx_strobe <= 1'b0;
      tx_byte   <= '0;
    end else begin
      status    <= status_n;
      data      <= data_n;
      irq       <= irq_n;
      tx_strobe <= tx_go;
      if (tx_go) tx_byte <= wdata[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/serial_csr_top.sv
module serial_csr_top
  import serial_csr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_ready,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq
);
  reg_sel_t                          sel;
  logic                              rd, wr;
  logic [NUM_PLAIN-1:0]              plain_we;
  logic [NUM_PLAIN-1:0][DATA_W-1:0]  plain;
  logic [DATA_W-1:0]                 status;
  logic [BYTE_W-1:0]                 data;
  logic [DATA_W-1:0]                 rd_mux;

  assign rd = req_valid & ~req_write;
  assign wr = req_valid &  req_write;

  serial_csr_decode #(.ADDR_W(ADDR_W)) dec_i (
    .addr (req_addr),
    .sel  (sel)
  );

  for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_we
    assign plain_we[g] = wr && sel.kind == SEL_PLAIN && sel.plain_idx == 3'(g);
  end

  serial_csr_store #(.DATA_W(DATA_W), .NREG(NUM_PLAIN)) store_i (
    .clk   (clk),
    .rst   (rst),
    .wr_en (plain_we),
    .wdata (req_wdata),
    .regs  (plain)
  );

  serial_csr_flags #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) flags_i (
    .clk       (clk),
    .rst       (rst),
    .rd_status (rd && sel.kind == SEL_STATUS),
    .rd_data   (rd && sel.kind == SEL_DATA),
    .wr_status (wr && sel.kind == SEL_STATUS),
    .wr_data   (wr && sel.kind == SEL_DATA),
    .wr_ctl1   (plain_we[PL_CTL1]),
    .wdata     (req_wdata),
    .ctl1      (plain[PL_CTL1]),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .rx_ready  (rx_ready),
    .status    (status),
    .data      (data),
    .irq       (irq),
    .tx_strobe (tx_strobe),
    .tx_byte   (tx_byte)
  );

  always_comb begin
    case (sel.kind)
      SEL_STATUS: rd_mux = status;
      SEL_DATA:   rd_mux = DATA_W'(data);
      SEL_PLAIN:  rd_mux = plain[sel.plain_idx];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/serial_csr_checker.sv
module serial_csr_checker #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_strobe,
  input logic              irq
);
  logic data_wr_ok, data_rd, rx_take;
  assign data_wr_ok = req_valid && req_write && req_addr == ADDR_W'('h4)
                      && req_wdata < DATA_W'('hF000);
  assign data_rd    = req_valid && !req_write && req_addr == ADDR_W'('h4);
  assign rx_take    = rx_valid && rx_ready;

  // R7: a transmit pulse only follows an accepted data write
  a_r7_tx_from_write: assert property (@(posedge clk) disable iff (rst)
    tx_strobe |-> $past(data_wr_ok));

  // R4: a data read with no byte arriving leaves the interrupt low
  a_r4_read_drops_irq: assert property (@(posedge clk) disable iff (rst)
    $past(data_rd && !rx_take) |-> !irq);

  // R3: the interrupt only rises while a byte is held
  a_r3_irq_needs_data: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> !rx_ready);

  // R11: a response follows every read request
  a_r11_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid);

  // R9: quiet outputs on leaving reset
  a_r9_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && !tx_strobe && !rsp_valid));
endmodule

bind serial_csr_top serial_csr_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .tx_strobe (tx_strobe),
  .irq       (irq)
);

// File: tb/serial_csr_top_tb_top.sv
module serial_csr_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_ready, tx_strobe, irq;
  logic [7:0]  tx_byte;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [31:0] m_sr, m_baud, m_c1, m_c2, m_c3, m_gt;
  logic [7:0]  m_dr;
  logic        m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_csr_top dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_ready(rx_ready), .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [AW-1:0] a);
    case (a)
      'h00: return m_sr;
      'h04: return {24'h0, m_dr};
      'h08: return m_baud;
      'h0C: return m_c1;
      'h10: return m_c2;
      'h14: return m_c3;
      'h18: return m_gt;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    m_sr = 32'hC0; m_dr = 0; m_baud = 0; m_c1 = 0; m_c2 = 0; m_c3 = 0; m_gt = 0; m_irq = 0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input string req);
    logic [31:0] exp;
    exp = model_read(a);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk("R11 rsp_valid", 32'(rsp_valid), 32'd1);
    chk(req, rsp_rdata, exp);
    if (a == 'h00) m_sr[6] = 1'b0;                          // R5
    if (a == 'h04) begin m_sr[7] = 1; m_sr[5] = 0; m_irq = 0; end  // R4
    @(negedge clk);
    chk("R4/R5 irq after read", 32'(irq), 32'(m_irq));
    chk("R1 rx_ready", 32'(rx_ready), 32'(!m_sr[5]));
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] v);
    bit tx_exp;
    tx_exp = 0;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = v;
    case (a)
      'h00: begin
        m_sr = (v <= 32'h3FF) ? v : (m_sr & v);             // R6
        if (!m_sr[5]) m_irq = 0;
      end
      'h04: if (v < 32'hF000) begin                          // R7
        tx_exp = 1; m_sr[6] = 1; m_sr[7] = 0;
      end
      'h08: m_baud = v;
      'h0C: begin m_c1 = v; if (v[5] && m_sr[5]) m_irq = 1; end  // R8
      'h10: m_c2 = v;
      'h14: m_c3 = v;
      'h18: m_gt = v;
      default: ;                                             // R10
    endcase
    @(negedge clk);
    req_valid = 0; req_write = 0;
    chk("R7 tx_strobe", 32'(tx_strobe), 32'(tx_exp));
    if (tx_exp) chk("R7 tx_byte", 32'(tx_byte), 32'(v[7:0]));
    chk("R3/R6/R8 irq", 32'(irq), 32'(m_irq));
    @(negedge clk);
    chk("R7 strobe one cycle", 32'(tx_strobe), 32'd0);
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk);
    chk("R1 rx_ready before push", 32'(rx_ready), 32'(!m_sr[5]));
    rx_valid = 1; rx_byte = b;
    if (!m_sr[5]) begin
      m_dr = b;                                              // R2
      if (m_c1[13] && m_c1[2]) begin
        m_sr[5] = 1;
        if (m_c1[5]) m_irq = 1;                              // R3
      end
    end
    @(negedge clk);
    rx_valid = 0;
    chk("R2/R3 irq after push", 32'(irq), 32'(m_irq));
    chk("R1 rx_ready after push", 32'(rx_ready), 32'(!m_sr[5]));
  endtask

  function automatic logic [AW-1:0] pick_addr(input int unsigned r);
    case (r % 9)
      0: return 'h00; 1: return 'h04; 2: return 'h08; 3: return 'h0C;
      4: return 'h10; 5: return 'h14; 6: return 'h18; 7: return 'h1C;
      default: return 'h1FFC;
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5EED1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    chk("R9 irq", 32'(irq), 0);
    chk("R9 tx_strobe", 32'(tx_strobe), 0);
    chk("R9 rsp_valid", 32'(rsp_valid), 0);
    for (int a = 0; a <= 'h18; a += 4) bus_read(AW'(a), "R9 reset value");

    // R2: byte with receiver disabled is stored but not flagged
    rx_push(8'hA5);
    bus_read('h04, "R2 dropped byte still stored");
    bus_read('h00, "R2 flag stays clear");
    // R3: enabled receive with interrupt
    bus_write('h0C, 32'h2024);
    rx_push(8'h3C);
    rx_push(8'h77);                      // R1: refused, data unchanged
    bus_read('h04, "R1/R4 data read keeps first byte");
    bus_read('h00, "R4 status after data read");
    // R8: late enable raises irq
    bus_write('h0C, 32'h2004);
    rx_push(8'h11);
    bus_write('h0C, 32'h2024);
    bus_write('h0C, 32'h2004);           // irq holds with enable cleared
    // R6 boundaries
    bus_write('h00, 32'h3FF);
    bus_read('h00, "R6 replace at 0x3FF");
    bus_write('h00, 32'h400 | 32'hFFFF_FBDF);
    bus_read('h00, "R6 AND path clears data-available");
    // R7 boundaries
    bus_write('h04, 32'hEFFF);
    bus_write('h04, 32'hF000);
    bus_read('h00, "R5 status shows done, then cleared");
    bus_read('h00, "R5 done cleared by read");
    // R10 plain regs and holes
    bus_write('h08, 32'h1234_5678);
    bus_write('h18, 32'hCAFE_0001);
    bus_write('h1C, 32'hFFFF_FFFF);
    bus_write('h02, 32'hFFFF_FFFF);
    bus_read('h08, "R10 baud readback");
    bus_read('h18, "R10 guard readback");
    bus_read('h1C, "R10 hole reads zero");
    bus_read('h02, "R10 unaligned reads zero");

    // constrained random
    for (int i = 0; i < 600; i++) begin
      int unsigned r, op;
      logic [AW-1:0] a;
      logic [31:0] v;
      r = $urandom; op = r % 4; a = pick_addr($urandom);
      if (op == 0) rx_push(8'($urandom));
      else if (op == 1) bus_read(a, "R10 random read");
      else begin
        v = $urandom;
        if (a == 'h00) v = ($urandom % 2) ? (v & 32'h3FF) : (v | 32'h400);
        if (a == 'h04) v = ($urandom % 2) ? (v % 32'hF000) : (32'hF000 + (v % 32'h100));
        if (a == 'h0C) v = (v & 32'h0000_0024) | (($urandom % 4 != 0) ? 32'h2000 : 0);
        bus_write(a, v);
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule